// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides which of a set of local interrupt units an interrupt command is aimed at. A command carries a low word (with a destination-mode bit and a two-bit shorthand), a high word (with an 8-bit destination), and the index of the unit that sent it. Every unit presents its own ID word, logical destination word and destination format word. For each unit the block decides independently whether that unit is a target, and it returns the result as one bit per unit.

Three addressing styles are resolved. In physical addressing, units are picked by their 8-bit ID, and destination 0xFF is a broadcast. In logical addressing, each unit's format word selects one of two models: a flat bitmask, or a cluster-plus-member model. A format value outside these two matches nothing. A non-zero shorthand overrides the destination altogether and selects the sender, every unit, or every unit except the sender. The decision logic is combinational. The mask is registered, so the result appears one clock after the command.

Top module: `intr_dest_matcher`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tgt_valid` is 0 and `tgt_mask` is all zeros.
- R2: In physical mode (low-word bit 11 = 0) with shorthand 00, unit u matches when the destination (high-word bits 31:24) equals bits 31:24 of that unit's ID word. The other bits of the ID word are not used.
- R3: In physical mode with shorthand 00, destination 0xFF matches every unit.
- R4: In logical mode (bit 11 = 1) with shorthand 00, a unit whose format word has upper nibble 0xF uses the flat model. It matches when its logical ID (bits 31:24 of its logical destination word) ANDed with the destination is non-zero.
- R5: In logical mode, a unit whose format upper nibble is 0x0 uses the cluster model. It matches when the upper nibble of its logical ID equals the upper nibble of the destination, and the two lower nibbles ANDed together are non-zero.
- R6: In logical mode, a unit whose format upper nibble is any value other than 0xF or 0x0 never matches. Bits 27:0 of the format word are treated as ones, so they have no effect. Physical matching of that unit is unaffected.
- R7: Shorthand 01 (bits 19:18) matches only the unit whose index equals the source index. A source index at or above the unit count matches no unit.
- R8: Shorthand 10 matches every unit.
- R9: Shorthand 11 matches every unit except the source unit. A source index at or above the unit count yields all units.
- R10: Under a non-zero shorthand, the destination field, the mode bit and all unit words have no effect on the mask.
- R11: Only low-word bits 11 and 19:18 and high-word bits 31:24 influence the result. Every other command bit is ignored.
- R12: A command sampled with `cmd_valid` high at a clock edge gives `tgt_valid` high and its mask at that same edge. This is one register stage. After an edge with `cmd_valid` low, `tgt_valid` is low and `tgt_mask` is zero. Commands may arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_lo | input | 32 | Command low word: bit 11 mode, bits 19:18 shorthand |
| cmd_hi | input | 32 | Command high word: bits 31:24 destination |
| cmd_src | input | SRC_W | Index of the sending unit |
| unit_id | input | NUM_UNITS*32 | Per-unit ID words, unit u at bits [32u+31:32u] |
| unit_ldr | input | NUM_UNITS*32 | Per-unit logical destination words, same packing |
| unit_dfr | input | NUM_UNITS*32 | Per-unit destination format words, same packing |
| tgt_valid | output | 1 | Registered: a mask is presented this cycle |
| tgt_mask | output | NUM_UNITS | Registered one-hot-per-unit target mask |

## Verification
The bench builds the block with six units, which gives a three-bit source index. Indices 6 and 7 are therefore legal port values that name no unit, and they exercise the out-of-range source behaviour of the self and all-but-self shorthands. With six units, a single configuration can also mix flat, cluster and invalid format words across units. That setup shows the format is decided separately for each target, and it lets the all-units and broadcast masks be told apart from a power-of-two width.

// File: rtl/idm_pkg.sv
package idm_pkg;

  localparam int WORD_W    = 32;
  localparam int DEST_W    = 8;
  localparam int MODE_BIT  = 11;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;
  localparam int NIB_W     = 4;
  localparam logic [WORD_W-1:0] FMT_FORCE = 32'h0FFF_FFFF;
  localparam logic [NIB_W-1:0]  FMT_FLAT_NIB    = 4'hF;
  localparam logic [NIB_W-1:0]  FMT_CLUSTER_NIB = 4'h0;
  localparam logic [DEST_W-1:0] DEST_BCAST      = 8'hFF;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef enum logic [1:0] {
    FMT_FLAT    = 2'd0,
    FMT_CLUSTER = 2'd1,
    FMT_INVALID = 2'd2
  } fmt_e;

  typedef struct packed {
    logic              logical;
    shorthand_e        sh;
    logic [DEST_W-1:0] dest;
  } cmd_t;

endpackage

// File: rtl/idm_cmd_decode.sv
module idm_cmd_decode
  import idm_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output cmd_t              cmd
);

  logic unused_cmd_bits;

  always_comb begin
    cmd.logical = lo_word[MODE_BIT];
    cmd.sh      = shorthand_e'(lo_word[SH_LSB +: 2]);
    cmd.dest    = hi_word[DEST_LSB +: DEST_W];
  end

  assign unused_cmd_bits = ^{lo_word[WORD_W-1:SH_LSB+2], lo_word[SH_LSB-1:MODE_BIT+1],
                             lo_word[MODE_BIT-1:0], hi_word[DEST_LSB-1:0]};

endmodule

// File: rtl/idm_unit_match.sv
module idm_unit_match
  import idm_pkg::*;
#(
  parameter int UNIT_IDX = 0,
  parameter int SRC_W    = 1
) (
  input  cmd_t              cmd,
  input  logic [SRC_W-1:0]  src,
  input  logic [WORD_W-1:0] id_word,
  input  logic [WORD_W-1:0] ldr_word,
  input  logic [WORD_W-1:0] dfr_word,
  output logic              hit
);

  localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(UNIT_IDX);

  logic [WORD_W-1:0] dfr_eff;
  logic [DEST_W-1:0] my_id;
  logic [DEST_W-1:0] my_log;
  fmt_e              fmt;
  logic              phys_hit;
  logic              flat_hit;
  logic              clus_hit;
  logic              log_hit;
  logic              is_self;
  logic              unused_unit_bits;

  assign dfr_eff = dfr_word | FMT_FORCE;
  assign my_id   = id_word[DEST_LSB +: DEST_W];
  assign my_log  = ldr_word[DEST_LSB +: DEST_W];
  assign is_self = (src == MY_IDX);

  always_comb begin
    unique case (dfr_eff[WORD_W-1 -: NIB_W])
      FMT_FLAT_NIB:    fmt = FMT_FLAT;
      FMT_CLUSTER_NIB: fmt = FMT_CLUSTER;
      default:         fmt = FMT_INVALID;
    endcase
  end

  always_comb begin
    phys_hit = (cmd.dest == DEST_BCAST) || (cmd.dest == my_id);
    flat_hit = |(my_log & cmd.dest);
    clus_hit = (my_log[DEST_W-1 -: NIB_W] == cmd.dest[DEST_W-1 -: NIB_W]) &&
               (|(my_log[NIB_W-1:0] & cmd.dest[NIB_W-1:0]));
    unique case (fmt)
      FMT_FLAT:    log_hit = flat_hit;
      FMT_CLUSTER: log_hit = clus_hit;
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cmd.sh)
      SH_NONE:   hit = cmd.logical ? log_hit : phys_hit;
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = 1'b0;
    endcase
  end

  assign unused_unit_bits = ^{dfr_eff[WORD_W-NIB_W-1:0], id_word[DEST_LSB-1:0],
                              ldr_word[DEST_LSB-1:0]};

endmodule

// File: rtl/idm_out_reg.sv
module idm_out_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_mask,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      out_mask  <= in_valid ? in_mask : '0;
    end
  end

endmodule

// File: rtl/intr_dest_matcher.sv
module intr_dest_matcher
  import idm_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int SRC_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [WORD_W-1:0]           cmd_lo,
  input  logic [WORD_W-1:0]           cmd_hi,
  input  logic [SRC_W-1:0]            cmd_src,
  input  logic [NUM_UNITS*WORD_W-1:0] unit_id,
  input  logic [NUM_UNITS*WORD_W-1:0] unit_ldr,
  input  logic [NUM_UNITS*WORD_W-1:0] unit_dfr,
  output logic                        tgt_valid,
  output logic [NUM_UNITS-1:0]        tgt_mask
);

  cmd_t                 cmd;
  logic [NUM_UNITS-1:0] hit_vec;

  idm_cmd_decode u_decode (
    .lo_word (cmd_lo),
    .hi_word (cmd_hi),
    .cmd     (cmd)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    idm_unit_match #(
      .UNIT_IDX (u),
      .SRC_W    (SRC_W)
    ) u_match (
      .cmd      (cmd),
      .src      (cmd_src),
      .id_word  (unit_id [u*WORD_W +: WORD_W]),
      .ldr_word (unit_ldr[u*WORD_W +: WORD_W]),
      .dfr_word (unit_dfr[u*WORD_W +: WORD_W]),
      .hit      (hit_vec[u])
    );
  end

  idm_out_reg #(
    .WIDTH (NUM_UNITS)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cmd_valid),
    .in_mask   (hit_vec),
    .out_valid (tgt_valid),
    .out_mask  (tgt_mask)
  );

endmodule

// File: rtl/idm_checker.sv
module idm_checker #(
  parameter int NUM_UNITS = 8,
  parameter int SRC_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [31:0]          cmd_lo,
  input logic [31:0]          cmd_hi,
  input logic [SRC_W-1:0]     cmd_src,
  input logic                 tgt_valid,
  input logic [NUM_UNITS-1:0] tgt_mask
);

  logic [1:0] sh;
  logic       in_range;
  assign sh       = cmd_lo[19:18];
  assign in_range = (int'(cmd_src) < NUM_UNITS);

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> tgt_valid);

  assert_idle_follows_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !tgt_valid);

  assert_idle_mask_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !tgt_valid |-> (tgt_mask == '0));

  assert_bcast_all_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sh == 2'b00 && !cmd_lo[11] && cmd_hi[31:24] == 8'hFF)
      |=> (tgt_mask == '1));

  assert_self_single_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sh == 2'b01 && in_range) |=> ($countones(tgt_mask) == 1));

  assert_all_units_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sh == 2'b10) |=> (tgt_mask == '1));

  assert_others_count_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sh == 2'b11 && in_range) |=> ($countones(tgt_mask) == NUM_UNITS - 1));

endmodule

bind intr_dest_matcher idm_checker #(
  .NUM_UNITS (NUM_UNITS),
  .SRC_W     (SRC_W)
) u_idm_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_lo    (cmd_lo),
  .cmd_hi    (cmd_hi),
  .cmd_src   (cmd_src),
  .tgt_valid (tgt_valid),
  .tgt_mask  (tgt_mask)
);

// File: tb/intr_dest_matcher_tb.sv
`timescale 1ns/1ps
module intr_dest_matcher_tb;

  localparam int N  = 6;
  localparam int SW = 3;

  typedef struct {
    logic [N-1:0] mask;
    string        req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [31:0]     cmd_lo = '0;
  logic [31:0]     cmd_hi = '0;
  logic [SW-1:0]   cmd_src = '0;
  logic [N*32-1:0] unit_id, unit_ldr, unit_dfr;
  logic            tgt_valid;
  logic [N-1:0]    tgt_mask;

  logic [31:0] b_id  [N];
  logic [31:0] b_ldr [N];
  logic [31:0] b_dfr [N];

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int u = 0; u < N; u++) begin
      unit_id [u*32 +: 32] = b_id[u];
      unit_ldr[u*32 +: 32] = b_ldr[u];
      unit_dfr[u*32 +: 32] = b_dfr[u];
    end
  end

  intr_dest_matcher #(.NUM_UNITS(N), .SRC_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .cmd_src(cmd_src), .unit_id(unit_id), .unit_ldr(unit_ldr), .unit_dfr(unit_dfr),
    .tgt_valid(tgt_valid), .tgt_mask(tgt_mask)
  );

  function automatic logic [N-1:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                         input int src);
    logic [N-1:0] m;
    logic [7:0] d, lid;
    m = '0;
    d = hi[31:24];
    for (int u = 0; u < N; u++) begin
      lid = b_ldr[u][31:24];
      case (lo[19:18])
        2'b01: m[u] = (u == src);
        2'b10: m[u] = 1'b1;
        2'b11: m[u] = (u != src);
        default: begin
          if (!lo[11]) m[u] = (d == 8'hFF) || (d == b_id[u][31:24]);
          else if (b_dfr[u][31:28] == 4'hF) m[u] = (lid & d) != 0;
          else if (b_dfr[u][31:28] == 4'h0)
            m[u] = (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0);
          else m[u] = 1'b0;
        end
      endcase
    end
    return m;
  endfunction

  function automatic logic [31:0] mk_lo(input logic logical, input logic [1:0] sh,
                                        input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[11] = logical;
    w[19:18] = sh;
    return w;
  endfunction

  task automatic send(input logic [31:0] lo, input logic [31:0] hi, input int src,
                      input string req);
    exp_t e;
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; cmd_src = SW'(src); cmd_valid = 1'b1;
    e.mask = model(lo, hi, src);
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_lo = 32'hDEAD_BEEF; cmd_hi = 32'hFFFF_FFFF;
    end
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Monitor: compares each produced mask with the head of the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (tgt_valid) begin
          if (exp_q.size() == 0) begin
            n_cmp++; n_fail++;
            $display("FAIL R12: actual valid=1 mask=%b expected no result", tgt_mask);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.req, tgt_mask, e.mask);
          end
        end else begin
          chk("R12 idle mask", tgt_mask, '0);
          if (exp_q.size() != 0) begin
            n_cmp++; n_fail++;
            $display("FAIL R12: actual valid=0 expected valid=1 (%0d pending)", exp_q.size());
            void'(exp_q.pop_front());
          end
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_cmp++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    b_id[0] = 32'h00AB_CDEF; b_id[1] = 32'h0112_3456; b_id[2] = 32'h05FF_FFFF;
    b_id[3] = 32'h1000_0001; b_id[4] = 32'h2077_7777; b_id[5] = 32'hFE00_0000;
    b_ldr[0] = 32'h0100_00FF; b_ldr[1] = 32'h0200_0000; b_ldr[2] = 32'h0412_3456;
    b_ldr[3] = 32'h1100_0000; b_ldr[4] = 32'h12FF_FFFF; b_ldr[5] = 32'h8000_0000;
    for (int u = 0; u < N; u++) b_dfr[u] = 32'hFFFF_FFFF;

    // R1: reset state, held and just after release
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {{(N-1){1'b0}}, tgt_valid}, '0);
    chk("R1 reset mask", tgt_mask, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset mask", tgt_mask, '0);
    chk("R1 post-reset valid", {{(N-1){1'b0}}, tgt_valid}, '0);

    // R2 / R11: physical match with junk in unused bits
    send(mk_lo(1'b0, 2'b00, 32'hFFF3_F7FF), 32'h0500_FFFF, 0, "R2 dest 0x05");
    send(mk_lo(1'b0, 2'b00, 32'h0000_0000), 32'h1012_3456, 0, "R2 dest 0x10");
    send(mk_lo(1'b0, 2'b00, 32'hA5A0_A5A5), 32'h3300_0000, 1, "R2 no match");
    // R3: physical broadcast
    send(mk_lo(1'b0, 2'b00, 32'h1234_5678), 32'hFF00_0000, 2, "R3 broadcast");
    idle(2);
    // R4: flat logical
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h0300_0000, 0, "R4 flat 0x03");
    send(mk_lo(1'b1, 2'b00, 32'hFFF3_F7FF), 32'h8000_0000, 0, "R4 flat 0x80");
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h0000_FFFF, 0, "R4 flat zero dest");
    idle(2);
    // R5: cluster logical (raw value has zero low bits; forced ones must not matter)
    for (int u = 0; u < N; u++) b_dfr[u] = 32'h0000_0000;
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h1300_0000, 0, "R5 cluster 0x13");
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h0400_0000, 0, "R5 cluster 0x04");
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h1000_0000, 0, "R5 cluster empty members");
    idle(2);
    // R6: invalid format matches nothing logically; physical still works
    for (int u = 0; u < N; u++) b_dfr[u] = 32'h5000_0000;
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'hFF00_0000, 0, "R6 invalid format");
    send(mk_lo(1'b0, 2'b00, 32'h0), 32'h0100_0000, 0, "R6 physical unaffected");
    idle(1);
    // R4/R5/R6 mixed per-unit formats
    b_dfr[0] = 32'hF000_0000; b_dfr[1] = 32'h0FFF_FFFF; b_dfr[2] = 32'hFFFF_FFFF;
    b_dfr[3] = 32'h0123_4567; b_dfr[4] = 32'h7FFF_FFFF; b_dfr[5] = 32'hF000_0000;
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h1700_0000, 0, "R5 mixed formats");
    send(mk_lo(1'b1, 2'b00, 32'h0), 32'h8500_0000, 0, "R4 mixed formats");
    idle(2);
    // R7 / R10: self shorthand ignores dest and mode
    send(mk_lo(1'b1, 2'b01, 32'h0), 32'h0000_0000, 2, "R7 self src2");
    send(mk_lo(1'b0, 2'b01, 32'hFFFF_FFFF), 32'hFF00_0000, 5, "R10 self ignores bcast");
    send(mk_lo(1'b0, 2'b01, 32'h0), 32'h0500_0000, 7, "R7 self out of range");
    // R8
    send(mk_lo(1'b1, 2'b10, 32'h0), 32'h0000_0000, 3, "R8 all");
    // R9
    send(mk_lo(1'b0, 2'b11, 32'h0), 32'h0500_0000, 4, "R9 others src4");
    send(mk_lo(1'b1, 2'b11, 32'h0), 32'h0000_0000, 0, "R9 others src0");
    send(mk_lo(1'b0, 2'b11, 32'h0), 32'h0000_0000, 6, "R9 others out of range");
    idle(3);
    // R11: same fields, different junk, same answer
    send(mk_lo(1'b0, 2'b00, 32'h0000_0000), 32'h2000_0000, 0, "R11 clean");
    send(mk_lo(1'b0, 2'b00, 32'hFFFF_FFFF), 32'h20FF_FFFF, 0, "R11 junk");
    idle(4);

    chk("R12 drained", N'(exp_q.size()), '0);
    summary();
  end

endmodule